// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects the interrupt requests of a small signal-processing core and tells the core which handler to run next. There are eleven request sources. One is a nonmaskable power-down request. Six are active-low pins: three general external pins, two level pins and one edge pin. The rest are event pulses from the serial ports, the byte-DMA engine and the timer. Two of the pins can take over the two slots of the second serial port. Every source except power-down passes through its own mask bit. The highest-priority request that is still eligible is then registered onto a fixed vector address, and a one-cycle take strobe goes out with it.

Edge-type sources keep a latch until they are taken. Software can also set or clear these latches directly. Level-type sources count only while their pin is held low. An in-service vector records which handlers are active, and a return pulse removes the most urgent of them. A control bit selects how new requests are admitted. In nested mode, a request that outranks every active handler may interrupt. In sequential mode, nothing is taken until all handlers have returned. Each write to the mask holds back every maskable request for the following cycle.

Top module: `irq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the latches, the mask, the control register and the in-service state. After reset `vec_o` is 0x0000, `take_o` is low, every source is masked, the general pins are level-sensitive and the second serial port drives its own slots.
- R2: Source index i is also the priority rank, with 0 the most urgent. The order and vectors are: 0 power-down 0x002C, 1 ext2 0x0004, 2 L1 0x0008, 3 L0 0x000C, 4 port-0 tx 0x0010, 5 port-0 rx 0x0014, 6 edge pin 0x0018, 7 DMA 0x001C, 8 port-1 tx 0x0020, 9 port-1 rx 0x0024, 10 timer 0x0028. When several requests are eligible, the lowest index is taken.
- R3: `mask_wdata` bit i (for i = 1..10) gates source i, and 1 enables it. A masked source is never taken, but its latch survives. Once it is unmasked it is taken.
- R4: Power-down (index 0) ignores mask bit 0 and is never blocked by the mask-write hold.
- R5: `ctrl_wdata` bits 1, 2 and 3 make ext0, ext1 and ext2 edge-sensitive when set and level-sensitive when clear. A level-mode source requests only while its pin is low and keeps nothing once the pin is released.
- R6: L0 and L1 are always level-sensitive. The edge pin, power-down and the event inputs are always latched: pins on a falling edge, events on a rising edge. A latch clears in the cycle its source is taken.
- R7: `ctrl_wdata` bit 0 set selects nested mode, where a request is taken only if it outranks every in-service source. Clear selects sequential mode, where nothing is taken while any source is in service.
- R8: A `force_wr` cycle applies `force_clr` and then `force_set` to latch bit i of each edge-type source, so a set wins over a clear on the same bit. Bits of sources that are in level mode have no effect.
- R9: In the cycle after a mask write, no maskable request is taken.
- R10: An `rti` pulse removes the most urgent in-service source. A take in the same cycle is still recorded.
- R11: When `ctrl_wdata` bit 4 is set, the ext1 and ext0 pins feed the port-1 tx and rx slots (indices 8 and 9) and the port-1 events are ignored. When it is clear, the events feed the slots and those pins are ignored.
- R12: A level request present before clock edge k produces `take_o` high for exactly the cycle after edge k, with its vector. A falling edge on a pin first latches at edge k, so its take follows edge k+1. `vec_o` holds the last vector taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Power-down request, active low, falling-edge latched |
| ext0_n | input | 1 | General pin 0, active low |
| ext1_n | input | 1 | General pin 1, active low |
| ext2_n | input | 1 | General pin 2, active low |
| lvl0_n | input | 1 | Level pin L0, active low |
| lvl1_n | input | 1 | Level pin L1, active low |
| edge_e_n | input | 1 | Edge pin, active low |
| sp0_tx_evt | input | 1 | Serial port 0 transmit event |
| sp0_rx_evt | input | 1 | Serial port 0 receive event |
| sp1_tx_evt | input | 1 | Serial port 1 transmit event |
| sp1_rx_evt | input | 1 | Serial port 1 receive event |
| dma_evt | input | 1 | Byte-DMA event |
| timer_evt | input | 1 | Timer event |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 11 | New mask, bit i enables source i |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | {sp1 pins, ext2 edge, ext1 edge, ext0 edge, nest} |
| force_wr | input | 1 | Latch force/clear strobe |
| force_set | input | 11 | Latch bits to set |
| force_clr | input | 11 | Latch bits to clear |
| rti | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | Take-interrupt strobe |
| vec_o | output | 16 | Vector address |

## Verification
A return pulse and a new take can land on the same clock edge. The bench provokes this by raising `rti` together with L0 low while the timer handler is in service in nested mode. It then expects an immediate take of 0x000C. After one more return, a timer request in sequential mode must be accepted, which it can only be if the timer bit was really removed. Two other pairs are also made to coincide and judged against a behavioural model compared every cycle: a mask write with a power-down fall, and a force-set with a force-clear on the same bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 11;
    localparam int VW   = 16;

    typedef enum logic [3:0] {
        SRC_PWRDN = 4'd0, SRC_EXT2, SRC_LVL1, SRC_LVL0, SRC_SP0TX, SRC_SP0RX,
        SRC_EDGEE, SRC_DMA, SRC_SP1TX, SRC_SP1RX, SRC_TIMER
    } src_e;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef struct packed {
        logic sp1_pins;
        logic ext2_edge;
        logic ext1_edge;
        logic ext0_edge;
        logic nest;
    } ctrl_t;

    localparam int CW = $bits(ctrl_t);

    typedef struct packed {
        logic          take;
        logic [VW-1:0] vec;
    } core_req_t;

    function automatic logic [VW-1:0] vec_lut(input int idx);
        if (idx == int'(SRC_PWRDN)) return 16'h002C;
        return VW'(4 * idx);
    endfunction

    function automatic logic [VW-1:0] vec_of(input srcvec_t onehot);
        logic [VW-1:0] v;
        v = '0;
        for (int i = 0; i < NSRC; i++)
            if (onehot[i]) v = v | vec_lut(i);
        return v;
    endfunction

    function automatic srcvec_t lowest_set(input srcvec_t v);
        return v & (~v + srcvec_t'(1));
    endfunction
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] act,
    input  logic [N-1:0] lvl_mode,
    input  logic [N-1:0] set_sw,
    input  logic [N-1:0] clr_sw,
    input  logic [N-1:0] clr_take,
    output logic [N-1:0] req
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic prev_q;
        logic lat_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                lat_q  <= 1'b0;
            end else begin
                prev_q <= act[i];
                if (lvl_mode[i])
                    lat_q <= 1'b0;
                else
                    lat_q <= (lat_q & ~(clr_take[i] | clr_sw[i]))
                           | (act[i] & ~prev_q) | set_sw[i];
            end
        end

        assign req[i] = lvl_mode[i] ? act[i] : lat_q;

        // R6: a fresh edge on an edge-type source is held on the next cycle
        a_r6_edge_latches: assert property (@(posedge clk) disable iff (rst)
            (!lvl_mode[i] && act[i] && !prev_q) |=> lat_q);
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  srcvec_t req,
    input  srcvec_t mask,
    input  logic    hold,
    input  srcvec_t svc,
    input  logic    nest,
    output srcvec_t grant,
    output logic    valid
);
    localparam srcvec_t NMI_BIT = srcvec_t'(1) << int'(SRC_PWRDN);

    srcvec_t gate, room, cand;

    always_comb begin
        gate = hold ? NMI_BIT : (mask | NMI_BIT);
        if (svc == '0)
            room = '1;
        else if (nest)
            room = lowest_set(svc) - srcvec_t'(1);
        else
            room = '0;
        cand = req & gate & room;
    end

    assign grant = lowest_set(cand);
    assign valid = |cand;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pwrdn_n,
    input  logic            ext0_n,
    input  logic            ext1_n,
    input  logic            ext2_n,
    input  logic            lvl0_n,
    input  logic            lvl1_n,
    input  logic            edge_e_n,
    input  logic            sp0_tx_evt,
    input  logic            sp0_rx_evt,
    input  logic            sp1_tx_evt,
    input  logic            sp1_rx_evt,
    input  logic            dma_evt,
    input  logic            timer_evt,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] mask_wdata,
    input  logic            ctrl_wr,
    input  logic [CW-1:0]   ctrl_wdata,
    input  logic            force_wr,
    input  logic [NSRC-1:0] force_set,
    input  logic [NSRC-1:0] force_clr,
    input  logic            rti,
    output logic            take_o,
    output logic [VW-1:0]   vec_o
);
    ctrl_t     ctrl_q;
    srcvec_t   mask_q, svc_q, svc_d;
    logic      hold_q;
    core_req_t out_q;

    srcvec_t   act, lvl_mode, req, grant, set_sw, clr_sw;
    logic      valid;

    always_comb begin
        act                  = '0;
        act[SRC_PWRDN]       = ~pwrdn_n;
        act[SRC_EXT2]        = ~ext2_n;
        act[SRC_LVL1]        = ~lvl1_n;
        act[SRC_LVL0]        = ~lvl0_n;
        act[SRC_SP0TX]       = sp0_tx_evt;
        act[SRC_SP0RX]       = sp0_rx_evt;
        act[SRC_EDGEE]       = ~edge_e_n;
        act[SRC_DMA]         = dma_evt;
        act[SRC_SP1TX]       = ctrl_q.sp1_pins ? ~ext1_n : sp1_tx_evt;
        act[SRC_SP1RX]       = ctrl_q.sp1_pins ? ~ext0_n : sp1_rx_evt;
        act[SRC_TIMER]       = timer_evt;

        lvl_mode             = '0;
        lvl_mode[SRC_LVL1]   = 1'b1;
        lvl_mode[SRC_LVL0]   = 1'b1;
        lvl_mode[SRC_EXT2]   = ~ctrl_q.ext2_edge;
        lvl_mode[SRC_SP1TX]  = ctrl_q.sp1_pins & ~ctrl_q.ext1_edge;
        lvl_mode[SRC_SP1RX]  = ctrl_q.sp1_pins & ~ctrl_q.ext0_edge;

        set_sw = force_wr ? force_set : '0;
        clr_sw = force_wr ? force_clr : '0;
    end

    irq_latch_bank #(.N(NSRC)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .lvl_mode (lvl_mode),
        .set_sw   (set_sw),
        .clr_sw   (clr_sw),
        .clr_take (grant),
        .req      (req)
    );

    irq_arbiter u_arb (
        .req   (req),
        .mask  (mask_q),
        .hold  (hold_q),
        .svc   (svc_q),
        .nest  (ctrl_q.nest),
        .grant (grant),
        .valid (valid)
    );

    always_comb begin
        svc_d = svc_q;
        if (rti) svc_d = svc_d & ~lowest_set(svc_q);
        svc_d = svc_d | grant;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
            hold_q <= 1'b0;
            svc_q  <= '0;
            out_q  <= '0;
        end else begin
            hold_q <= mask_wr;
            if (mask_wr) mask_q <= mask_wdata;
            if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_wdata);
            svc_q      <= svc_d;
            out_q.take <= valid;
            if (valid) out_q.vec <= vec_of(grant);
        end
    end

    assign take_o = out_q.take;
    assign vec_o  = out_q.vec;

    // R1: reset leaves the core-facing outputs and state idle
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!take_o && vec_o == '0 && svc_q == '0 && mask_q == '0));

    // R7: sequential mode never takes while a handler is active
    a_r7_sequential_blocks: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.nest && svc_q != '0) |=> !take_o);

    // R4: an idle controller always takes power-down first
    a_r4_pwrdn_first: assert property (@(posedge clk) disable iff (rst)
        (req[SRC_PWRDN] && svc_q == '0) |=> (take_o && vec_o == 16'h002C));

    // R9: during the post-write hold only power-down may pass
    a_r9_hold_only_pwrdn: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !req[SRC_PWRDN]) |=> !take_o);

    // R3: nothing unmasked pending means no take
    a_r3_masked_idle: assert property (@(posedge clk) disable iff (rst)
        (!req[SRC_PWRDN] && (req & mask_q) == '0) |=> !take_o);

    // R10: a return with no new take removes exactly one active handler
    a_r10_rti_pops: assert property (@(posedge clk) disable iff (rst)
        (rti && svc_q != '0 && !valid) |=>
        ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // R12: a take always leaves a handler recorded as active
    a_r12_take_marks_svc: assert property (@(posedge clk) disable iff (rst)
        take_o |-> svc_q != '0);
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwrdn_n = 1, ext0_n = 1, ext1_n = 1, ext2_n = 1, lvl0_n = 1, lvl1_n = 1, edge_e_n = 1;
    logic sp0_tx_evt = 0, sp0_rx_evt = 0, sp1_tx_evt = 0, sp1_rx_evt = 0, dma_evt = 0, timer_evt = 0;
    logic mask_wr = 0, ctrl_wr = 0, force_wr = 0, rti = 0;
    logic [10:0] mask_wdata = '0, force_set = '0, force_clr = '0;
    logic [4:0]  ctrl_wdata = '0;
    logic        take_o;
    logic [15:0] vec_o;

    int    n_chk = 0, n_err = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
        .ext2_n(ext2_n), .lvl0_n(lvl0_n), .lvl1_n(lvl1_n), .edge_e_n(edge_e_n),
        .sp0_tx_evt(sp0_tx_evt), .sp0_rx_evt(sp0_rx_evt), .sp1_tx_evt(sp1_tx_evt),
        .sp1_rx_evt(sp1_rx_evt), .dma_evt(dma_evt), .timer_evt(timer_evt),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .force_wr(force_wr), .force_set(force_set),
        .force_clr(force_clr), .rti(rti), .take_o(take_o), .vec_o(vec_o)
    );

    // ---------------- behavioural reference model ----------------
    bit [10:0] m_lat, m_prev, m_svc, m_mask;
    bit        m_hold, m_nest, m_e0, m_e1, m_e2, m_sp1p, m_take;
    logic [15:0] m_vec;

    function automatic logic [15:0] ref_vec(input int k);
        case (k)
            0: return 16'h002C;  1: return 16'h0004;  2: return 16'h0008;
            3: return 16'h000C;  4: return 16'h0010;  5: return 16'h0014;
            6: return 16'h0018;  7: return 16'h001C;  8: return 16'h0020;
            9: return 16'h0024;  default: return 16'h0028;
        endcase
    endfunction

    always @(posedge clk) begin
        bit [10:0] a, lv, rq;
        int pick, top;
        if (rst) begin
            m_lat = 0; m_prev = 0; m_svc = 0; m_mask = 0; m_hold = 0;
            {m_sp1p, m_e2, m_e1, m_e0, m_nest} = 0; m_take = 0; m_vec = 0;
        end else begin
            a = 0; lv = 0;
            a[0] = !pwrdn_n; a[1] = !ext2_n; a[2] = !lvl1_n; a[3] = !lvl0_n;
            a[4] = sp0_tx_evt; a[5] = sp0_rx_evt; a[6] = !edge_e_n; a[7] = dma_evt;
            a[8] = m_sp1p ? !ext1_n : sp1_tx_evt;
            a[9] = m_sp1p ? !ext0_n : sp1_rx_evt;
            a[10] = timer_evt;
            lv[1] = !m_e2; lv[2] = 1; lv[3] = 1;
            lv[8] = m_sp1p && !m_e1; lv[9] = m_sp1p && !m_e0;
            for (int i = 0; i < 11; i++) rq[i] = lv[i] ? a[i] : m_lat[i];
            top = 99;
            for (int i = 10; i >= 0; i--) if (m_svc[i]) top = i;
            pick = -1;
            for (int i = 0; i < 11; i++)
                if (pick < 0 && rq[i] && (i == 0 || (m_mask[i] && !m_hold)) &&
                    (top == 99 || (m_nest && i < top)))
                    pick = i;
            for (int i = 0; i < 11; i++) begin
                if (lv[i]) m_lat[i] = 0;
                else begin
                    if (i == pick || (force_wr && force_clr[i])) m_lat[i] = 0;
                    if ((a[i] && !m_prev[i]) || (force_wr && force_set[i])) m_lat[i] = 1;
                end
                m_prev[i] = a[i];
            end
            if (rti && top != 99) m_svc[top] = 0;
            m_take = (pick >= 0);
            if (pick >= 0) begin
                m_svc[pick] = 1;
                m_vec = ref_vec(pick);
            end
            m_hold = mask_wr;
            if (mask_wr) m_mask = mask_wdata;
            if (ctrl_wr) {m_sp1p, m_e2, m_e1, m_e0, m_nest} = ctrl_wdata;
        end
    end

    always @(negedge clk) begin
        n_chk++;
        if (take_o !== m_take || vec_o !== m_vec) begin
            n_err++;
            $display("FAIL %s per-cycle: take=%0b vec=%h expected take=%0b vec=%h",
                     cur_req, take_o, vec_o, m_take, m_vec);
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string r, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", r, what, got, exp);
        end
    endtask

    task automatic wait_take(input logic [15:0] exp, input string r);
        int n = 0;
        do begin @(negedge clk); n++; end while (!take_o && n < 12);
        chk(take_o === 1'b1 && vec_o === exp, r, "take vector", vec_o, exp);
    endtask

    task automatic quiet(input int n, input string r);
        bit seen = 0;
        repeat (n) begin @(negedge clk); if (take_o) seen = 1; end
        chk(!seen, r, "unexpected take", {15'd0, seen}, 16'd0);
    endtask

    task automatic ret();
        rti = 1; @(negedge clk); rti = 0;
    endtask

    task automatic wmask(input logic [10:0] v);
        mask_wr = 1; mask_wdata = v; @(negedge clk); mask_wr = 0;
    endtask

    task automatic wctrl(input bit sp1, input bit e2, input bit e1, input bit e0, input bit nest);
        ctrl_wr = 1; ctrl_wdata = {sp1, e2, e1, e0, nest}; @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic wforce(input logic [10:0] s, input logic [10:0] c);
        force_wr = 1; force_set = s; force_clr = c; @(negedge clk);
        force_wr = 0; force_set = 0; force_clr = 0;
    endtask

    task automatic pulse_timer();
        timer_evt = 1; @(negedge clk); timer_evt = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(take_o === 0 && vec_o === 16'h0000, "R1", "reset outputs", vec_o, 16'h0000);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        dma_evt = 1; @(negedge clk); dma_evt = 0;
        quiet(3, "R1");
        wforce(0, 11'h080);

        // R9: hold after a mask write, then L1 taken
        cur_req = "R9";
        wmask(11'h7FF);
        lvl1_n = 0;
        @(negedge clk);
        chk(take_o === 0, "R9", "take during hold", {15'd0, take_o}, 16'd0);
        @(negedge clk);
        chk(take_o === 1 && vec_o === 16'h0008, "R9", "take after hold", vec_o, 16'h0008);
        lvl1_n = 1; ret();

        // R2 / R6: simultaneous latched requests drain in priority order
        cur_req = "R2";
        sp0_tx_evt = 1; sp0_rx_evt = 1; dma_evt = 1; timer_evt = 1; edge_e_n = 0;
        @(negedge clk);
        sp0_tx_evt = 0; sp0_rx_evt = 0; dma_evt = 0; timer_evt = 0; edge_e_n = 1;
        wait_take(16'h0010, "R2"); ret();
        wait_take(16'h0014, "R2"); ret();
        wait_take(16'h0018, "R6"); ret();
        wait_take(16'h001C, "R2"); ret();
        wait_take(16'h0028, "R2"); ret();

        // R3: masked source keeps its latch
        cur_req = "R3";
        wmask(11'h77F);
        dma_evt = 1; @(negedge clk); dma_evt = 0;
        quiet(5, "R3");
        wmask(11'h7FF);
        wait_take(16'h001C, "R3"); ret();

        // R4: power-down with mask cleared and during the hold
        cur_req = "R4";
        mask_wr = 1; mask_wdata = 11'h000; pwrdn_n = 0;
        @(negedge clk); mask_wr = 0;
        @(negedge clk);
        chk(take_o === 1 && vec_o === 16'h002C, "R4", "power-down in hold", vec_o, 16'h002C);
        pwrdn_n = 1; ret();
        wmask(11'h7FF);

        // R7: nested preemption
        cur_req = "R7";
        wctrl(0, 0, 0, 0, 1);
        pulse_timer(); wait_take(16'h0028, "R7");
        lvl0_n = 0; wait_take(16'h000C, "R7");
        lvl0_n = 1; ret(); ret();
        // R7: sequential blocks until return
        wctrl(0, 0, 0, 0, 0);
        pulse_timer(); wait_take(16'h0028, "R7");
        lvl0_n = 0; quiet(4, "R7");
        ret(); wait_take(16'h000C, "R7");
        lvl0_n = 1; ret();

        // R10: return and take on the same edge
        cur_req = "R10";
        wctrl(0, 0, 0, 0, 1);
        pulse_timer(); wait_take(16'h0028, "R10");
        rti = 1; lvl0_n = 0;
        @(negedge clk); rti = 0;
        chk(take_o === 1 && vec_o === 16'h000C, "R10", "take with return", vec_o, 16'h000C);
        lvl0_n = 1; ret();
        wctrl(0, 0, 0, 0, 0);
        pulse_timer(); wait_take(16'h0028, "R10"); ret();

        // R5: ext2 level mode keeps nothing, edge mode latches, level taken while low
        cur_req = "R5";
        pulse_timer(); wait_take(16'h0028, "R5");
        ext2_n = 0; repeat (2) @(negedge clk); ext2_n = 1;
        ret(); quiet(4, "R5");
        wctrl(0, 1, 0, 0, 0);
        ext2_n = 0; @(negedge clk); ext2_n = 1;
        wait_take(16'h0004, "R5"); ret();
        wctrl(0, 0, 0, 0, 0);
        ext2_n = 0; wait_take(16'h0004, "R5");
        ext2_n = 1; ret();

        // R8: force and clear of latches
        cur_req = "R8";
        pulse_timer(); wait_take(16'h0028, "R8");
        wforce(11'h040, 0); wforce(0, 11'h040);
        ret(); quiet(4, "R8");
        wforce(11'h400, 0); wait_take(16'h0028, "R8"); ret();
        wforce(11'h008, 0); quiet(4, "R8");
        wforce(11'h080, 11'h080); wait_take(16'h001C, "R8"); ret();

        // R11: second serial port slots from pins or events
        cur_req = "R11";
        wctrl(1, 0, 1, 1, 0);
        sp1_rx_evt = 1; @(negedge clk); sp1_rx_evt = 0;
        quiet(4, "R11");
        ext0_n = 0; @(negedge clk); ext0_n = 1;
        wait_take(16'h0024, "R11"); ret();
        wctrl(0, 0, 1, 1, 0);
        ext1_n = 0; @(negedge clk); ext1_n = 1;
        quiet(4, "R11");
        sp1_tx_evt = 1; @(negedge clk); sp1_tx_evt = 0;
        wait_take(16'h0020, "R11"); ret();

        // R12: exact timing of level and edge requests
        cur_req = "R12";
        lvl1_n = 0; @(negedge clk);
        chk(take_o === 1 && vec_o === 16'h0008, "R12", "level take timing", vec_o, 16'h0008);
        @(negedge clk);
        chk(take_o === 0 && vec_o === 16'h0008, "R12", "strobe width and hold", vec_o, 16'h0008);
        lvl1_n = 1; ret();
        edge_e_n = 0; @(negedge clk);
        chk(take_o === 0, "R12", "edge not yet taken", {15'd0, take_o}, 16'd0);
        edge_e_n = 1; @(negedge clk);
        chk(take_o === 1 && vec_o === 16'h0018, "R12", "edge take timing", vec_o, 16'h0018);
        ret();

        // R1: mid-run reset with a handler active
        cur_req = "R1";
        pulse_timer(); wait_take(16'h0028, "R1");
        rst = 1; repeat (2) @(negedge clk); rst = 0;
        chk(take_o === 0 && vec_o === 16'h0000, "R1", "outputs after reset", vec_o, 16'h0000);
        timer_evt = 1; @(negedge clk); timer_evt = 0;
        quiet(4, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule